// File: doc/BRIEF.md
# Cascaded Sixteen-Line Interrupt Controller

This block combines two eight-input priority interrupt controllers into a single sixteen-line interrupt source for a CPU. Lines 0 to 7 feed the primary controller and lines 8 to 15 feed the secondary. The secondary's pending-request indication is chained into input 2 of the primary, so the CPU has one interrupt wire. That wire is a registered output that is recomputed every clock.

The CPU answers with a one-cycle acknowledge pulse. On the edge that ends the pulse, the block picks the winning line and updates the request, in-service and rotation state of the controller or controllers involved. One cycle later it returns an 8-bit vector and the 4-bit line number that was served. Each vector is the controller's programmed 5-bit base in bits 7:3 and a 3-bit line index in bits 2:0.

Per-controller configuration comes in as plain inputs from a register file outside this block. That configuration is the mask, the trigger select, the vector base, automatic end-of-interrupt, rotation on automatic end-of-interrupt, and a non-specific end-of-interrupt strobe.

Top module: `pic_pair`

## Requirements
- R1: Line n is handled by controller n>>3 on input n&7. A primary winner w other than 2 acknowledges to vector {base_m_i, w} and reported line w.
- R2: While the secondary has a qualifying request, primary input 2 is set as a latched edge. An acknowledge whose primary winner is 2 also acknowledges the secondary winner s, and returns vector {base_s_i, s} and reported line 8+s.
- R3: External line 2 has no effect on the request state, the interrupt output or the vector.
- R4: An acknowledge with no primary winner is spurious. It returns vector {base_m_i, 7} and line 7, and it changes no state.
- R5: If the primary winner is 2 but the secondary has no winner, the block returns vector {base_s_i, 7} and line 15. The secondary state stays unchanged, while the primary acknowledges its input 2.
- R6: With automatic end-of-interrupt off, an acknowledge sets the in-service bit of the line. While that bit is set, requests of equal or lower priority do not qualify. A strobe on eoi_i[c] clears the highest-priority in-service bit of controller c.
- R7: With aeoi_i[c]=1, an acknowledge sets no in-service bit. If rot_aeoi_i[c]=1 as well, the lowest-priority position becomes the acknowledged line, so the new rotation offset is (line+1) mod 8. Priority is highest at the offset and decreases in ascending index order, with wrap-around.
- R8: On an edge-triggered line (trig bit 0), the request is set by a 0-to-1 transition and cleared by acknowledge. On a level-triggered line (trig bit 1), the request follows the input and acknowledge does not clear it.
- R9: Trigger-select bits are effective only where the mask allows: 0xF8 for trig_i[7:0] and 0xDE for trig_i[15:8]. Every other line is edge-triggered.
- R10: A request whose imr_i bit is 1 never qualifies and does not raise cpu_int_o.
- R11: After reset, cpu_int_o and vec_valid_o are 0 and all request, in-service and rotation state is clear. cpu_int_o equals the primary's qualifying state of the previous cycle.
- R12: vec_valid_o is 1 exactly in the cycle after an inta_i cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_i | input | 16 | External interrupt lines |
| imr_i | input | 16 | Per-line mask, 1 = masked |
| trig_i | input | 16 | Per-line trigger select, 1 = level |
| base_m_i | input | 5 | Primary vector base (vector bits 7:3) |
| base_s_i | input | 5 | Secondary vector base |
| aeoi_i | input | 2 | Automatic end-of-interrupt, bit 0 primary, bit 1 secondary |
| rot_aeoi_i | input | 2 | Rotate on automatic end-of-interrupt, per controller |
| eoi_i | input | 2 | Non-specific end-of-interrupt strobe, per controller |
| inta_i | input | 1 | Acknowledge pulse |
| cpu_int_o | output | 1 | Interrupt request to the CPU |
| vec_valid_o | output | 1 | Vector valid, one cycle after acknowledge |
| vec_o | output | 8 | Returned vector |
| vec_line_o | output | 4 | Line number served (0 to 15) |

## Verification
The bench targets the two spurious paths. A design that mishandles the primary path would return a real line or corrupt in-service state. A design that mishandles the secondary path would acknowledge the stale slave or report a primary vector. A secondary level-triggered line that drops after the primary has latched input 2 is the stimulus that exposes the secondary path.

The bench also drives the following cases, each of which catches a specific fault:
- Requests raised on external line 2: a broken design would interrupt the CPU on that line.
- Level lines held across an acknowledge: a broken design would lose the request.
- Rotation after automatic end-of-interrupt: a broken design would serve lines in a fixed order.
- Trigger bits written outside the allowed masks: a broken design would make those lines level-sensitive and re-raise them forever.

// File: rtl/pic_pair_pkg.sv
package pic_pair_pkg;
  localparam int unsigned CTL_LINES = 8;
  localparam int unsigned CTL_LW    = $clog2(CTL_LINES);

  // priority rank: 0 = highest, CTL_LINES = nothing found
  typedef logic [CTL_LW:0] prio_t;

  function automatic prio_t find_prio(input logic [CTL_LINES-1:0] m,
                                      input logic [CTL_LW-1:0] rot);
    prio_t p;
    p = prio_t'(CTL_LINES);
    for (int k = CTL_LINES - 1; k >= 0; k--) begin
      if (m[(k + int'(rot)) % CTL_LINES]) p = prio_t'(k);
    end
    return p;
  endfunction
endpackage

// File: rtl/pic_pair_ctl.sv
module pic_pair_ctl
  import pic_pair_pkg::*;
#(
  parameter logic [CTL_LINES-1:0] TRIG_MASK = '1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [CTL_LINES-1:0] lines_i,
  input  logic [CTL_LINES-1:0] pulse_i,
  input  logic [CTL_LINES-1:0] imr_i,
  input  logic [CTL_LINES-1:0] trig_i,
  input  logic                 aeoi_i,
  input  logic                 rot_aeoi_i,
  input  logic                 eoi_i,
  input  logic                 ack_i,
  output logic                 win_valid_o,
  output logic [CTL_LW-1:0]    win_line_o
);
  logic [CTL_LINES-1:0] irr_q, isr_q, prev_q;
  logic [CTL_LW-1:0]    rot_q;
  prio_t                req_p, svc_p;
  logic [CTL_LINES-1:0] trig_eff, ack_oh, eoi_oh, irr_n, isr_n;
  logic [CTL_LW-1:0]    svc_line;

  always_comb begin
    req_p       = find_prio(irr_q & ~imr_i, rot_q);
    svc_p       = find_prio(isr_q, rot_q);
    win_valid_o = (req_p < svc_p);
    win_line_o  = req_p[CTL_LW-1:0] + rot_q;
    svc_line    = svc_p[CTL_LW-1:0] + rot_q;
    trig_eff    = trig_i & TRIG_MASK;
    ack_oh      = ack_i ? (CTL_LINES'(1) << win_line_o) : '0;
    eoi_oh      = (eoi_i && !svc_p[CTL_LW]) ? (CTL_LINES'(1) << svc_line) : '0;
    irr_n       = (trig_eff & lines_i)
                | (~trig_eff & ((irr_q & ~ack_oh) | (lines_i & ~prev_q)))
                | pulse_i;
    isr_n       = (isr_q & ~eoi_oh) | (aeoi_i ? '0 : ack_oh);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irr_q  <= '0;
      isr_q  <= '0;
      prev_q <= '0;
      rot_q  <= '0;
    end else begin
      irr_q  <= irr_n;
      isr_q  <= isr_n;
      prev_q <= lines_i;
      if (ack_i && aeoi_i && rot_aeoi_i) rot_q <= win_line_o + CTL_LW'(1);
    end
  end
endmodule

// File: rtl/pic_pair.sv
module pic_pair
  import pic_pair_pkg::*;
#(
  parameter int unsigned            VEC_W       = 8,
  parameter int unsigned            CASCADE     = 2,
  parameter logic [CTL_LINES-1:0]   M_TRIG_MASK = 8'hF8,
  parameter logic [CTL_LINES-1:0]   S_TRIG_MASK = 8'hDE,
  localparam int unsigned           NUM         = 2 * CTL_LINES,
  localparam int unsigned           BASE_W      = VEC_W - CTL_LW
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM-1:0]    irq_i,
  input  logic [NUM-1:0]    imr_i,
  input  logic [NUM-1:0]    trig_i,
  input  logic [BASE_W-1:0] base_m_i,
  input  logic [BASE_W-1:0] base_s_i,
  input  logic [1:0]        aeoi_i,
  input  logic [1:0]        rot_aeoi_i,
  input  logic [1:0]        eoi_i,
  input  logic              inta_i,
  output logic              cpu_int_o,
  output logic              vec_valid_o,
  output logic [VEC_W-1:0]  vec_o,
  output logic [CTL_LW:0]   vec_line_o
);
  localparam logic [CTL_LINES-1:0] CAS_BIT = CTL_LINES'(1) << CASCADE;

  logic                 m_valid, s_valid, m_ack, s_ack, m_is_cas;
  logic [CTL_LW-1:0]    m_line, s_line, s_sel;
  logic [CTL_LINES-1:0] m_lines, m_pulse;

  always_comb begin
    m_lines  = irq_i[CTL_LINES-1:0] & ~CAS_BIT;
    m_is_cas = (m_line == CTL_LW'(CASCADE));
    m_ack    = inta_i && m_valid;
    s_ack    = m_ack && m_is_cas && s_valid;
    m_pulse  = (s_valid && !s_ack) ? CAS_BIT : '0;
    s_sel    = s_valid ? s_line : '1;
  end

  pic_pair_ctl #(.TRIG_MASK(M_TRIG_MASK)) u_m (
    .clk(clk), .rst(rst), .lines_i(m_lines), .pulse_i(m_pulse),
    .imr_i(imr_i[CTL_LINES-1:0]), .trig_i(trig_i[CTL_LINES-1:0]),
    .aeoi_i(aeoi_i[0]), .rot_aeoi_i(rot_aeoi_i[0]), .eoi_i(eoi_i[0]),
    .ack_i(m_ack), .win_valid_o(m_valid), .win_line_o(m_line)
  );

  pic_pair_ctl #(.TRIG_MASK(S_TRIG_MASK)) u_s (
    .clk(clk), .rst(rst), .lines_i(irq_i[NUM-1:CTL_LINES]), .pulse_i('0),
    .imr_i(imr_i[NUM-1:CTL_LINES]), .trig_i(trig_i[NUM-1:CTL_LINES]),
    .aeoi_i(aeoi_i[1]), .rot_aeoi_i(rot_aeoi_i[1]), .eoi_i(eoi_i[1]),
    .ack_i(s_ack), .win_valid_o(s_valid), .win_line_o(s_line)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cpu_int_o   <= 1'b0;
      vec_valid_o <= 1'b0;
      vec_o       <= '0;
      vec_line_o  <= '0;
    end else begin
      cpu_int_o   <= m_valid;
      vec_valid_o <= inta_i;
      if (inta_i) begin
        if (!m_valid) begin
          vec_o      <= {base_m_i, {CTL_LW{1'b1}}};
          vec_line_o <= {1'b0, {CTL_LW{1'b1}}};
        end else if (m_is_cas) begin
          vec_o      <= {base_s_i, s_sel};
          vec_line_o <= {1'b1, s_sel};
        end else begin
          vec_o      <= {base_m_i, m_line};
          vec_line_o <= {1'b0, m_line};
        end
      end
    end
  end
endmodule

// File: rtl/pic_pair_chk.sv
module pic_pair_chk
  import pic_pair_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              inta_i,
  input logic              m_valid,
  input logic [CTL_LW-1:0] m_line,
  input logic              vec_valid_o,
  input logic [7:0]        vec_o,
  input logic [CTL_LW:0]   vec_line_o
);
  p_vec_after_ack_r12: assert property (@(posedge clk) disable iff (rst)
    inta_i |=> vec_valid_o);
  p_vec_only_after_ack_r12: assert property (@(posedge clk) disable iff (rst)
    !inta_i |=> !vec_valid_o);
  p_spurious_master_r4: assert property (@(posedge clk) disable iff (rst)
    (inta_i && !m_valid) |=> (vec_line_o == 4'd7 && vec_o[2:0] == 3'd7));
  p_cascade_line_r2: assert property (@(posedge clk) disable iff (rst)
    (inta_i && m_valid && m_line == 3'd2) |=> vec_line_o[CTL_LW]);
  p_master_line_r1: assert property (@(posedge clk) disable iff (rst)
    (inta_i && m_valid && m_line != 3'd2)
      |=> (!vec_line_o[CTL_LW] && vec_line_o[CTL_LW-1:0] == $past(m_line)));
endmodule

bind pic_pair pic_pair_chk chk_i (
  .clk(clk), .rst(rst), .inta_i(inta_i), .m_valid(m_valid), .m_line(m_line),
  .vec_valid_o(vec_valid_o), .vec_o(vec_o), .vec_line_o(vec_line_o)
);

// File: tb/pic_pair_tb_top.sv
module pic_pair_tb_top;
  logic        clk = 1'b0, rst = 1'b1;
  logic [15:0] irq = '0, imr = '0, trig = '0;
  logic [4:0]  bm = 5'h01, bs = 5'h0E;
  logic [1:0]  aeoi = '0, rot = '0, eoi = '0;
  logic        inta = 1'b0;
  logic        cpu_int, vv;
  logic [7:0]  vec;
  logic [3:0]  vline;
  int          checks = 0, errors = 0;
  string       tag = "R11";

  always #2 clk = ~clk;

  pic_pair dut_i (
    .clk(clk), .rst(rst), .irq_i(irq), .imr_i(imr), .trig_i(trig),
    .base_m_i(bm), .base_s_i(bs), .aeoi_i(aeoi), .rot_aeoi_i(rot), .eoi_i(eoi),
    .inta_i(inta), .cpu_int_o(cpu_int), .vec_valid_o(vv), .vec_o(vec), .vec_line_o(vline)
  );

  // expected-behaviour model built from the requirements
  logic [7:0] b_irr[2], b_isr[2], b_prev[2];
  logic [2:0] b_rot[2];
  logic       b_int, b_vv;
  logic [7:0] b_vec;
  logic [3:0] b_line;

  function automatic int bprio(input logic [7:0] m, input logic [2:0] r);
    for (int k = 0; k < 8; k++) if (m[(k + int'(r)) % 8]) return k;
    return 8;
  endfunction

  always @(posedge clk) begin : mdl
    logic [7:0] lns[2];
    logic [7:0] tm, ao, eo, pul;
    logic [2:0] wl[2], el[2], sl;
    logic       val[2], ev[2], ack[2];
    int         pr, ip;
    if (rst) begin
      for (int c = 0; c < 2; c++) begin
        b_irr[c] = '0; b_isr[c] = '0; b_prev[c] = '0; b_rot[c] = '0;
      end
      b_int = 0; b_vv = 0; b_vec = '0; b_line = '0;
    end else begin
      lns[0] = irq[7:0] & 8'hFB;
      lns[1] = irq[15:8];
      for (int c = 0; c < 2; c++) begin
        pr = bprio(b_irr[c] & ~imr[c*8 +: 8], b_rot[c]);
        ip = bprio(b_isr[c], b_rot[c]);
        val[c] = pr < ip;
        wl[c]  = 3'(pr + int'(b_rot[c]));
        el[c]  = 3'(ip + int'(b_rot[c]));
        ev[c]  = ip < 8;
      end
      ack[0] = inta && val[0];
      ack[1] = ack[0] && wl[0] == 3'd2 && val[1];
      b_int = val[0];
      b_vv  = inta;
      if (inta) begin
        if (!val[0]) begin b_vec = {bm, 3'd7}; b_line = 4'd7; end
        else if (wl[0] == 3'd2) begin
          sl = val[1] ? wl[1] : 3'd7;
          b_vec = {bs, sl}; b_line = {1'b1, sl};
        end else begin b_vec = {bm, wl[0]}; b_line = {1'b0, wl[0]}; end
      end
      for (int c = 0; c < 2; c++) begin
        tm  = trig[c*8 +: 8] & (c == 0 ? 8'hF8 : 8'hDE);
        ao  = ack[c] ? (8'd1 << wl[c]) : 8'd0;
        eo  = (eoi[c] && ev[c]) ? (8'd1 << el[c]) : 8'd0;
        pul = (c == 0 && val[1] && !ack[1]) ? 8'h04 : 8'h00;
        b_irr[c] = (tm & lns[c]) | (~tm & ((b_irr[c] & ~ao) | (lns[c] & ~b_prev[c]))) | pul;
        b_isr[c] = (b_isr[c] & ~eo) | (aeoi[c] ? 8'd0 : ao);
        if (ack[c] && aeoi[c] && rot[c]) b_rot[c] = wl[c] + 3'd1;
        b_prev[c] = lns[c];
      end
    end
  end

  task automatic chk(input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      chk(cpu_int, b_int, "cpu_int_o");
      chk(vv, b_vv, "vec_valid_o");
      if (b_vv) begin
        chk(vec, b_vec, "vec_o");
        chk(vline, b_line, "vec_line_o");
      end
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic restart(input string t);
    @(negedge clk);
    rst = 1; irq = '0; imr = '0; trig = '0; aeoi = '0; rot = '0; eoi = '0; inta = 0;
    cyc(2);
    tag = t;
    rst = 0;
  endtask

  task automatic ack1();
    inta = 1; cyc(1); inta = 0; cyc(2);
  endtask

  task automatic eoi1(input logic [1:0] which);
    eoi = which; cyc(1); eoi = '0; cyc(1);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    // R11: reset state
    restart("R11");
    cyc(1);
    chk(cpu_int, 0, "reset cpu_int_o");
    chk(vv, 0, "reset vec_valid_o");
    cyc(3);
    // R1: primary line routed and vectored from primary base
    restart("R1");
    irq[5] = 1; cyc(3);
    chk(cpu_int, 1, "line5 raises cpu_int_o");
    ack1(); eoi1(2'b01); irq[5] = 0; cyc(2);
    // R3: external line 2 has no effect
    restart("R3");
    irq[2] = 1; cyc(4);
    chk(cpu_int, 0, "line2 ignored");
    ack1(); irq[2] = 0; cyc(2);
    // R2: secondary line through the cascade
    restart("R2");
    irq[12] = 1; cyc(4);
    ack1(); eoi1(2'b11); irq[12] = 0; cyc(2);
    // R5: secondary request vanishes after the primary latched input 2
    restart("R5");
    trig[9] = 1; irq[9] = 1; cyc(3);
    irq[9] = 0; cyc(2);
    ack1(); eoi1(2'b01); cyc(2);
    // R4: spurious acknowledge with nothing pending
    restart("R4");
    ack1(); ack1(); cyc(1);
    // R6: nesting and non-specific end-of-interrupt
    restart("R6");
    irq[4] = 1; cyc(3); ack1();
    irq[6] = 1; cyc(3);
    chk(cpu_int, 0, "lower priority blocked");
    irq[3] = 1; cyc(3); ack1();
    eoi1(2'b01); cyc(2); ack1(); eoi1(2'b01); eoi1(2'b01); cyc(2);
    // R7: automatic end-of-interrupt with rotation
    restart("R7");
    aeoi = 2'b11; rot = 2'b11;
    irq[1] = 1; irq[6] = 1; irq[0] = 1; cyc(3);
    ack1(); irq[1] = 0; cyc(1); irq[1] = 1; cyc(2);
    ack1(); ack1(); ack1(); cyc(2);
    // R8: level line stays pending across acknowledge
    restart("R8");
    trig[3] = 1; irq[3] = 1; cyc(3);
    ack1(); eoi1(2'b01); cyc(2);
    chk(cpu_int, 1, "level request kept");
    irq[3] = 0; cyc(3);
    // R9: trigger bits outside the masks stay edge
    restart("R9");
    trig = 16'hFFFF; irq[0] = 1; irq[8] = 1; cyc(3);
    ack1(); eoi1(2'b01); ack1(); eoi1(2'b11); cyc(3);
    // R10: masked request does not qualify
    restart("R10");
    imr[7] = 1; irq[7] = 1; cyc(4);
    chk(cpu_int, 0, "masked line7");
    ack1(); imr[7] = 0; cyc(3); ack1(); cyc(2);
    // R12: random traffic in several configurations
    restart("R12");
    for (int seg = 0; seg < 8; seg++) begin
      imr  = 16'($urandom & $urandom);
      trig = 16'($urandom);
      aeoi = 2'($urandom); rot = 2'($urandom);
      bm = 5'($urandom); bs = 5'($urandom);
      for (int i = 0; i < 400; i++) begin
        for (int b = 0; b < 16; b++) if ($urandom_range(15) == 0) irq[b] = ~irq[b];
        inta = ($urandom_range(5) == 0);
        eoi  = {($urandom_range(7) == 0), ($urandom_range(7) == 0)};
        cyc(1);
      end
      inta = 0; eoi = '0;
    end
    cyc(3);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #400000;
    checks++; errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule